// File: doc/BRIEF.md
# Command Response Capture Buffer

This block listens to the card's command line once a command has gone out, waits for the card's start bit, and shifts the response into a buffer one bit per card-clock rising edge. The buffer is then drained by software or a bus adapter as a stream of 16-bit halfwords, most significant first. The first halfword begins with the start bit of the frame.

The expected response shape comes from a 3-bit format code latched with the command-sent pulse. It can be nothing, a 48-bit short frame or a 136-bit long frame. When the frame is complete, the block raises a sticky end-of-response status bit and a one-cycle event. It also reports a missing response (timeout) and, for the one format that carries a checkable CRC-7, a CRC mismatch.

The read side is a valid/ready stream. A halfword is offered while `rsp_valid` is high and is consumed on a cycle where both `rsp_valid` and `rsp_ready` are high. While the consumer holds `rsp_ready` low, the same halfword stays on `rsp_data` indefinitely; the capture side never waits on the reader. Once all halfwords of the frame have been consumed, `rsp_valid` stays low and `rsp_data` reads zero.

Top module: `cmd_rsp_capture`

## Requirements
- R1: The format code, latched on `cmd_sent`, selects the frame length:
  - 1 is a 48-bit frame whose CRC is checked.
  - 3 is a 48-bit frame whose CRC is not checked.
  - 2 is a 136-bit frame.
  - 0 and 4 to 7 expect no response. In that case status bit 11 and the event are set on the clock edge that samples `cmd_sent`, and no halfword is offered.
- R2: After `cmd_sent`, the block samples `cmd_in` only on cycles where `card_clk_rise` is high. The first such sample that is 0 is the start bit, and it becomes bit 15 of halfword 0. Each later bit fills the next lower position.
- R3: A 48-bit frame is read as exactly three halfwords, most significant first.
- R4: A 136-bit frame is read as exactly nine halfwords. The low 8 bits of the ninth halfword are zero.
- R5: Status bit 11 and `rsp_end_evt` go high on the clock edge that samples the last frame bit.
  - `rsp_end_evt` lasts one cycle.
  - The status bits hold until the next `cmd_sent`.
- R6: If 64 consecutive card-clock samples after `cmd_sent` are all high, the response has timed out:
  - status bit 1 and bit 11 are set;
  - no halfword is offered.
  - A start bit on the 64th sample is still accepted.
- R7: For format 1, a CRC-7 (polynomial x^7+x^3+1, initial value zero) is computed over the first 40 frame bits and compared with frame bits 40 to 46, counted from the start bit as bit 0. A mismatch sets status bit 5. Formats 2 and 3 never set bit 5.
- R8: `rsp_valid` is high only after a complete frame and while halfwords remain. A halfword pops when valid and ready are both high. While ready is low, valid and data hold.
- R9: After the last halfword, `rsp_valid` is low and `rsp_data` is 0, and a high `rsp_ready` has no effect. A new `cmd_sent` clears the status bits and rewinds the read position to halfword 0.
- R10: After reset all status bits are 0, `rsp_valid` is low and `rsp_data` is 0. Status bits other than 11, 5 and 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_sent | input | 1 | One-cycle pulse: the command has finished, arm capture |
| rsp_fmt | input | 3 | Response format code, sampled with `cmd_sent` |
| card_clk_rise | input | 1 | High on system cycles that coincide with a card-clock rising edge |
| cmd_in | input | 1 | Card command line, already synchronised |
| rsp_valid | output | 1 | A response halfword is offered |
| rsp_ready | input | 1 | Consumer accepts the offered halfword |
| rsp_data | output | 16 | Offered halfword, zero when none |
| rsp_status | output | 16 | Bit 11 response finished, bit 5 CRC error, bit 1 timeout |
| rsp_end_evt | output | 1 | One-cycle pulse when status bit 11 becomes set |

## Verification
The main path is driven with frames of each format. The patterns are:
- short checked frames with a good CRC and with a single flipped CRC bit, which separates the compare from the capture path;
- a short unchecked frame carrying a wrong CRC field, which shows that the CRC check is gated by the format code;
- long frames, whose ninth halfword exposes the zero padding.

Start-bit delays range from none to 63 idle samples. This tells the timeout boundary apart from a late but valid response, and a directed case with 64 idle samples covers the timeout itself. The other directed cases are:
- an unused format code;
- reads past the end of a frame;
- a stall with `rsp_ready` held low;
- a new command issued mid-read, which shows that the read position rewinds.

// File: rtl/crsp_pkg.sv
`timescale 1ns/1ps
package crsp_pkg;

  typedef enum logic [2:0] {
    FMT_NONE  = 3'd0,
    FMT_SHORT = 3'd1,
    FMT_LONG  = 3'd2,
    FMT_NOCRC = 3'd3
  } rsp_fmt_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WAIT,
    PH_CAPT,
    PH_DONE
  } cap_phase_e;

  localparam int STATUS_W    = 16;
  localparam int ST_DONE_POS = 11;
  localparam int ST_CRC_POS  = 5;
  localparam int ST_TMO_POS  = 1;

  // One serial step of the 7-bit CRC, generator x^7 + x^3 + 1.
  function automatic logic [6:0] crc7_step(input logic [6:0] cur, input logic din);
    logic fb;
    fb = din ^ cur[6];
    return {cur[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic fmt_expects_frame(input logic [2:0] code);
    return (code == FMT_SHORT) || (code == FMT_LONG) || (code == FMT_NOCRC);
  endfunction

endpackage

// File: rtl/crsp_deser.sv
`timescale 1ns/1ps
module crsp_deser
  import crsp_pkg::*;
#(
  parameter int BUF_BITS   = 144,
  parameter int SHORT_BITS = 48,
  parameter int LONG_BITS  = 136,
  parameter int WAIT_LIMIT = 64,
  parameter int CRC_SPAN   = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [2:0]          fmt_i,
  input  logic                tick_i,
  input  logic                line_i,
  output logic [BUF_BITS-1:0] frame_o,
  output logic                done_o,
  output logic                tmo_o,
  output logic                crc_err_o,
  output logic                evt_o,
  output logic                avail_o,
  output logic                long_o
);

  localparam int CW     = $clog2(BUF_BITS + 1);
  localparam int WW     = $clog2(WAIT_LIMIT + 1);
  localparam int CRC_HI = BUF_BITS - 1 - CRC_SPAN;
  localparam logic [CW-1:0] TOP_C      = CW'(BUF_BITS - 1);
  localparam logic [CW-1:0] SPAN_C     = CW'(CRC_SPAN);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_BITS - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_BITS - 1);
  localparam logic [WW-1:0] WAIT_LAST  = WW'(WAIT_LIMIT - 1);

  cap_phase_e    phase;
  logic [CW-1:0] bit_cnt;
  logic [WW-1:0] idle_cnt;
  logic [6:0]    crc_q;
  logic          chk_crc_q;
  logic [CW-1:0] last_idx;

  assign last_idx = long_o ? LONG_LAST : SHORT_LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      frame_o   <= '0;
      bit_cnt   <= '0;
      idle_cnt  <= '0;
      crc_q     <= '0;
      chk_crc_q <= 1'b0;
      long_o    <= 1'b0;
      done_o    <= 1'b0;
      tmo_o     <= 1'b0;
      crc_err_o <= 1'b0;
      evt_o     <= 1'b0;
      avail_o   <= 1'b0;
    end else begin
      evt_o <= 1'b0;
      if (start_i) begin
        frame_o   <= '0;
        bit_cnt   <= '0;
        idle_cnt  <= '0;
        crc_q     <= '0;
        tmo_o     <= 1'b0;
        crc_err_o <= 1'b0;
        avail_o   <= 1'b0;
        long_o    <= (fmt_i == FMT_LONG);
        chk_crc_q <= (fmt_i == FMT_SHORT);
        if (fmt_expects_frame(fmt_i)) begin
          phase  <= PH_WAIT;
          done_o <= 1'b0;
        end else begin
          phase  <= PH_DONE;
          done_o <= 1'b1;
          evt_o  <= 1'b1;
        end
      end else if (tick_i) begin
        case (phase)
          PH_WAIT: begin
            if (!line_i) begin
              // start bit lands at the top of the buffer, already zero
              phase   <= PH_CAPT;
              bit_cnt <= CW'(1);
              crc_q   <= crc7_step(crc_q, 1'b0);
            end else if (idle_cnt == WAIT_LAST) begin
              phase  <= PH_DONE;
              tmo_o  <= 1'b1;
              done_o <= 1'b1;
              evt_o  <= 1'b1;
            end else begin
              idle_cnt <= idle_cnt + 1'b1;
            end
          end
          PH_CAPT: begin
            frame_o[TOP_C - bit_cnt] <= line_i;
            if (bit_cnt < SPAN_C) crc_q <= crc7_step(crc_q, line_i);
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == last_idx) begin
              phase     <= PH_DONE;
              done_o    <= 1'b1;
              evt_o     <= 1'b1;
              avail_o   <= 1'b1;
              crc_err_o <= chk_crc_q && (crc_q != frame_o[CRC_HI -: 7]);
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/crsp_rdport.sv
`timescale 1ns/1ps
module crsp_rdport #(
  parameter int HW_W     = 16,
  parameter int MAX_HW   = 9,
  parameter int SHORT_HW = 3,
  parameter int BUF_BITS = 144
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [BUF_BITS-1:0] frame_i,
  input  logic                avail_i,
  input  logic                long_i,
  input  logic                ready_i,
  output logic                valid_o,
  output logic [HW_W-1:0]     data_o
);

  localparam int PW = $clog2(MAX_HW + 1);
  localparam logic [PW-1:0] LONG_CNT  = PW'(MAX_HW);
  localparam logic [PW-1:0] SHORT_CNT = PW'(SHORT_HW);

  logic [HW_W-1:0] hw [MAX_HW];
  logic [PW-1:0]   ptr;
  logic [PW-1:0]   limit;
  logic [HW_W-1:0] sel;

  for (genvar g = 0; g < MAX_HW; g++) begin : g_slice
    assign hw[g] = frame_i[BUF_BITS-1-g*HW_W -: HW_W];
  end

  assign limit   = long_i ? LONG_CNT : SHORT_CNT;
  assign valid_o = avail_i && (ptr < limit);

  always_comb begin
    sel = '0;
    for (int k = 0; k < MAX_HW; k++) begin
      if (ptr == PW'(k)) sel = hw[k];
    end
  end

  assign data_o = valid_o ? sel : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                  ptr <= '0;
    else if (start_i)            ptr <= '0;
    else if (valid_o && ready_i) ptr <= ptr + 1'b1;
  end

endmodule

// File: rtl/cmd_rsp_capture.sv
`timescale 1ns/1ps
module cmd_rsp_capture
  import crsp_pkg::*;
#(
  parameter int HW_W       = 16,
  parameter int SHORT_BITS = 48,
  parameter int LONG_BITS  = 136,
  parameter int WAIT_LIMIT = 64,
  parameter int CRC_SPAN   = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_sent,
  input  logic [2:0]          rsp_fmt,
  input  logic                card_clk_rise,
  input  logic                cmd_in,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [HW_W-1:0]     rsp_data,
  output logic [STATUS_W-1:0] rsp_status,
  output logic                rsp_end_evt
);

  localparam int MAX_HW   = (LONG_BITS + HW_W - 1) / HW_W;
  localparam int SHORT_HW = (SHORT_BITS + HW_W - 1) / HW_W;
  localparam int BUF_BITS = MAX_HW * HW_W;

  logic [BUF_BITS-1:0] frame;
  logic done, tmo, crc_err, avail, is_long;

  crsp_deser #(
    .BUF_BITS  (BUF_BITS),
    .SHORT_BITS(SHORT_BITS),
    .LONG_BITS (LONG_BITS),
    .WAIT_LIMIT(WAIT_LIMIT),
    .CRC_SPAN  (CRC_SPAN)
  ) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (cmd_sent),
    .fmt_i    (rsp_fmt),
    .tick_i   (card_clk_rise),
    .line_i   (cmd_in),
    .frame_o  (frame),
    .done_o   (done),
    .tmo_o    (tmo),
    .crc_err_o(crc_err),
    .evt_o    (rsp_end_evt),
    .avail_o  (avail),
    .long_o   (is_long)
  );

  crsp_rdport #(
    .HW_W    (HW_W),
    .MAX_HW  (MAX_HW),
    .SHORT_HW(SHORT_HW),
    .BUF_BITS(BUF_BITS)
  ) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(cmd_sent),
    .frame_i(frame),
    .avail_i(avail),
    .long_i (is_long),
    .ready_i(rsp_ready),
    .valid_o(rsp_valid),
    .data_o (rsp_data)
  );

  always_comb begin
    rsp_status              = '0;
    rsp_status[ST_DONE_POS] = done;
    rsp_status[ST_CRC_POS]  = crc_err;
    rsp_status[ST_TMO_POS]  = tmo;
  end

endmodule

// File: rtl/crsp_chk.sv
`timescale 1ns/1ps
module crsp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_sent,
  input logic [2:0]  rsp_fmt,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_data,
  input logic [15:0] rsp_status,
  input logic        rsp_end_evt
);

  // R1: a format with no frame finishes at once and offers nothing
  p_fmt_none_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sent && !(rsp_fmt inside {3'd1, 3'd2, 3'd3})) |=> (rsp_status[11] && !rsp_valid));

  // R5: finishing raises the event in the same cycle
  p_done_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_status[11]) |-> rsp_end_evt);

  // R5: the event is a single-cycle pulse
  p_evt_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_end_evt && !cmd_sent) |=> !rsp_end_evt);

  // R6: a timeout finishes the response without CRC error or data
  p_tmo_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_status[1] |-> (rsp_status[11] && !rsp_status[5] && !rsp_valid));

  // R8: stalled halfword holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !cmd_sent) |=> (rsp_valid && $stable(rsp_data)));

  // R9: a new command clears errors and withdraws data
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sent |=> (!rsp_valid && !rsp_status[1] && !rsp_status[5]));

  // R10: unused status bits stay zero
  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_status & 16'hF7DD) == 16'h0000);

endmodule

bind cmd_rsp_capture crsp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_sent   (cmd_sent),
  .rsp_fmt    (rsp_fmt),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .rsp_status (rsp_status),
  .rsp_end_evt(rsp_end_evt)
);

// File: tb/sim_cmd_rsp_capture.sv
`timescale 1ns/1ps
module sim_cmd_rsp_capture;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cmd_sent = 1'b0;
  logic [2:0]  rsp_fmt = 3'd0;
  logic        card_clk_rise = 1'b0;
  logic        cmd_in = 1'b1;
  logic        rsp_ready = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [15:0] rsp_status;
  logic        rsp_end_evt;

  int errs = 0;
  int checks = 0;

  cmd_rsp_capture u0 (
    .clk(clk), .rst_n(rst_n), .cmd_sent(cmd_sent), .rsp_fmt(rsp_fmt),
    .card_clk_rise(card_clk_rise), .cmd_in(cmd_in), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_status(rsp_status),
    .rsp_end_evt(rsp_end_evt)
  );

  typedef struct packed {
    logic [2:0]  fmt;
    logic [31:0] seed;
    logic        bad;
    logic [6:0]  delay;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 32'h1234_5678, 1'b0, 7'd0},
    '{3'd1, 32'hCAFE_0001, 1'b1, 7'd5},
    '{3'd3, 32'h0BAD_F00D, 1'b0, 7'd2},
    '{3'd2, 32'h7777_1111, 1'b0, 7'd1},
    '{3'd2, 32'h2468_ACE1, 1'b0, 7'd63},
    '{3'd1, 32'h5555_AAAA, 1'b0, 7'd10},
    '{3'd5, 32'h0000_0001, 1'b0, 7'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void build(input vec_t v, output logic [143:0] f, output int len);
    logic [31:0] s;
    logic [6:0]  c;
    s = v.seed;
    f = '0;
    len = (v.fmt == 3'd2) ? 136 : 48;
    for (int i = 0; i < len; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      f[143-i] = s[0];
    end
    f[143] = 1'b0;
    f[142] = 1'b0;
    f[144-len] = 1'b1;
    if (v.fmt == 3'd1) begin
      c = '0;
      for (int i = 0; i < 40; i++) begin
        if (f[143-i] != c[6]) c = {c[5:0], 1'b0} ^ 7'b0001001;
        else                  c = {c[5:0], 1'b0};
      end
      if (v.bad) c[0] = ~c[0];
      f[103:97] = c;
    end else if (v.fmt == 3'd3) begin
      f[103:97] = 7'h7F;
    end
  endfunction

  task automatic send_bit(input logic b);
    cmd_in = b;
    card_clk_rise = 1'b1;
    @(negedge clk);
    card_clk_rise = 1'b0;
    cmd_in = 1'b1;
  endtask

  task automatic issue(input logic [2:0] f);
    rsp_fmt = f;
    cmd_sent = 1'b1;
    @(negedge clk);
    cmd_sent = 1'b0;
  endtask

  task automatic pop;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic send_frame(input logic [143:0] f, input int len);
    for (int i = 0; i < len; i++) send_bit(f[143-i]);
  endtask

  initial begin
    #(5.0 * 150000);
    errs++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [143:0] f;
    int len;
    int nhw;
    logic [15:0] exp_st;

    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset status", rsp_status, 16'h0000);
    check("R10 reset valid", rsp_valid, 1'b0);
    check("R10 reset data", rsp_data, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 0; n < NV; n++) begin
      vec_t v;
      v = VECS[n];
      issue(v.fmt);
      if (!(v.fmt inside {3'd1, 3'd2, 3'd3})) begin
        // R1: no frame expected
        check("R1 none status", rsp_status, 16'h0800);
        check("R1 none evt", rsp_end_evt, 1'b1);
        check("R1 none valid", rsp_valid, 1'b0);
        pop;
        check("R9 none data after ready", rsp_data, 16'h0000);
        continue;
      end
      build(v, f, len);
      nhw = (v.fmt == 3'd2) ? 9 : 3;
      for (int d = 0; d < v.delay; d++) send_bit(1'b1);
      check("R6 no early timeout", rsp_status, 16'h0000);
      send_frame(f, len - 1);
      check("R5 not done before last bit", rsp_status[11], 1'b0);
      send_bit(f[144-len]);
      exp_st = 16'h0800 | ((v.fmt == 3'd1 && v.bad) ? 16'h0020 : 16'h0000);
      check("R7 status after frame", rsp_status, exp_st);
      check("R5 end event", rsp_end_evt, 1'b1);
      @(negedge clk);
      check("R5 event single", rsp_end_evt, 1'b0);
      // R8: stall holds first halfword
      check("R8 valid", rsp_valid, 1'b1);
      check("R2 first halfword", rsp_data, f[143 -: 16]);
      @(negedge clk);
      check("R8 held data", rsp_data, f[143 -: 16]);
      for (int k = 0; k < nhw; k++) begin
        check(nhw == 9 ? "R4 halfword valid" : "R3 halfword valid", rsp_valid, 1'b1);
        check(nhw == 9 ? "R4 halfword data" : "R3 halfword data", rsp_data, f[143-16*k -: 16]);
        pop;
      end
      check("R9 past end valid", rsp_valid, 1'b0);
      check("R9 past end data", rsp_data, 16'h0000);
      pop;
      check("R9 ready ignored", rsp_data, 16'h0000);
      check("R5 status sticky", rsp_status, exp_st);
    end

    // R6: timeout after 64 idle samples
    issue(3'd1);
    for (int d = 0; d < 63; d++) send_bit(1'b1);
    check("R6 not yet timed out", rsp_status, 16'h0000);
    send_bit(1'b1);
    check("R6 timeout status", rsp_status, 16'h0802);
    check("R6 timeout event", rsp_end_evt, 1'b1);
    check("R6 timeout no data", rsp_valid, 1'b0);

    // R9: a new command mid-read rewinds and clears
    build(VECS[0], f, len);
    issue(3'd1);
    check("R9 cleared after command", rsp_status, 16'h0000);
    send_frame(f, len);
    pop;
    check("R9 second halfword", rsp_data, f[127 -: 16]);
    issue(3'd1);
    check("R9 rewound valid low", rsp_valid, 1'b0);
    send_frame(f, len);
    check("R9 rewound first halfword", rsp_data, f[143 -: 16]);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule